// File: doc/BRIEF.md
# Buffered Thread Result Voter

This block checks write-back results in a pipeline that runs the same instruction on redundant hardware threads in turn. The copies of one instruction's result reach the block in different clock cycles, so each thread's copy (a destination register index plus data) waits in a buffer of its own. The vote happens only once the last active copy has arrived. In the normal two-thread mode, two buffered copies that agree produce one register-file write. Two copies that disagree produce no write. Instead the block pulses a mismatch flag and raises a recovery level, which tells the rest of the core to wake the auxiliary thread.

While the block is in recovery, it waits for the auxiliary thread's copy of the same instruction. It then takes the two-of-three majority over the auxiliary copy and the two disagreeing copies it still holds. The majority value goes to the register file, and the block returns to two-thread mode. If all three copies differ, the block writes nothing and enters a dead state, which only reset clears. The index and the data are compared as one word, so a disagreement in the index counts the same as a disagreement in the data.

Top module: `wbv_top`

## Requirements
- R1: After reset, rf_we_o, mismatch_o, recover_o and fatal_o are all 0. Reset also leaves the block in two-thread mode with all buffers empty.
- R2: When the copies from thread IDs 2 and 1 hold the same index and data, rf_we_o goes high for exactly one cycle, with that index and data. This happens in the cycle after the clock edge that captures the later copy, and it does not depend on which thread's copy arrives first.
- R3: A single buffered copy causes no write, however many cycles pass before its partner copy arrives.
- R4: When the two primary copies differ in index, in data or in both, no write occurs. In the cycle where the commit would have appeared, mismatch_o pulses high for one cycle, and recover_o goes high and stays high.
- R5: In recovery, once the copy from thread ID 0 (the auxiliary thread) is captured, the next cycle shows rf_we_o high with the value that at least two of the three copies share. recover_o is low in that same cycle.
- R6: In recovery, if all three copies differ, the block writes nothing and fatal_o rises. fatal_o then stays high, and every later input is ignored until reset.
- R7: All buffers are emptied by a commit or by a recovery resolution. A single new copy after either event therefore causes no write.
- R8: A copy from thread ID 0 is ignored in two-thread mode. A copy from thread ID 3 is ignored in every mode.
- R9: A second copy from a thread that already has a copy waiting is ignored, and the first copy is kept.
- R10: A copy captured on the same clock edge that commits the previous instruction is kept for the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid_i | input | 1 | Result copy present this cycle |
| res_tid_i | input | 2 | Thread ID of the copy: 0 auxiliary, 1 and 2 primary, 3 unused |
| res_idx_i | input | 5 | Destination register index |
| res_data_i | input | 32 | Result data |
| rf_we_o | output | 1 | Register-file write enable, high for one cycle per commit |
| rf_idx_o | output | 5 | Index to write |
| rf_data_o | output | 32 | Data to write |
| mismatch_o | output | 1 | One-cycle pulse when the two primary copies disagree |
| recover_o | output | 1 | High while the block waits for the auxiliary copy |
| fatal_o | output | 1 | High once three copies have all disagreed; cleared only by reset |

## Verification
A buffer that fails to empty would show up one instruction later. A lone new copy would then pair with stale contents and produce an early or wrong write, which the bench catches the moment it sends a single copy after each commit. A full flag stuck low or stuck high shows up in the cycle after the second copy: the expected write is missing, or a mismatch appears where the copies agree. A wrong mode register shows up directly on recover_o or fatal_o, or as an auxiliary copy that resolves nothing. Checks therefore sample the outputs exactly one cycle after each capturing edge, and again a few cycles later when a quiet output is expected.

// File: rtl/wbv_pkg.sv
package wbv_pkg;

    // Operating mode of the voter
    typedef enum logic [1:0] {
        MODE_PAIR    = 2'd0,   // two primary copies, compare only
        MODE_RECOVER = 2'd1,   // waiting for the auxiliary copy
        MODE_DEAD    = 2'd2    // three-way disagreement seen
    } vmode_e;

    // One buffer per hardware thread
    localparam int unsigned NUM_SLOTS = 3;

endpackage

// File: rtl/wbv_slot.sv
// One thread's result buffer. A write is accepted when the slot is empty
// or is being emptied in the same cycle; otherwise it is dropped.
module wbv_slot #(
    parameter int unsigned WORD_W = 37
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              clr_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              full_o,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic              full;
        logic [WORD_W-1:0] word;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (take_i && (!slot_q.full || clr_i)) begin
            slot_d.full = 1'b1;
            slot_d.word = word_i;
        end else if (clr_i) begin
            slot_d.full = 1'b0;
            slot_d.word = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign full_o = slot_q.full;
    assign word_o = slot_q.word;

endmodule

// File: rtl/wbv_route.sv
// Decodes the thread ID into per-slot capture strobes. The auxiliary slot
// listens only in recovery; primary slots listen only in two-thread mode.
module wbv_route #(
    parameter int unsigned TID_W     = 2,
    parameter int unsigned NUM_SLOTS = 3,
    parameter int unsigned AUX_TID   = 0
) (
    input  logic                 valid_i,
    input  logic [TID_W-1:0]     tid_i,
    input  logic                 pair_mode_i,
    input  logic                 recover_mode_i,
    output logic [NUM_SLOTS-1:0] take_o
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_take
        if (g == AUX_TID) begin : g_aux
            assign take_o[g] = valid_i && (tid_i == TID_W'(g)) && recover_mode_i;
        end else begin : g_prim
            assign take_o[g] = valid_i && (tid_i == TID_W'(g)) && pair_mode_i;
        end
    end

endmodule

// File: rtl/wbv_vote3.sv
// Pure combinational comparison of three buffered words.
module wbv_vote3 #(
    parameter int unsigned WORD_W = 37
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [WORD_W-1:0] c_i,
    output logic              pair_eq_o,
    output logic              maj_ok_o,
    output logic [WORD_W-1:0] maj_word_o
);

    logic eq_ab, eq_ac, eq_bc;

    always_comb begin
        eq_ab      = (a_i == b_i);
        eq_ac      = (a_i == c_i);
        eq_bc      = (b_i == c_i);
        pair_eq_o  = eq_ab;
        maj_ok_o   = eq_ab | eq_ac | eq_bc;
        maj_word_o = (eq_ab || eq_ac) ? a_i : b_i;
    end

endmodule

// File: rtl/wbv_top.sv
module wbv_top #(
    parameter int unsigned IDX_W   = 5,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned TID_W   = 2,
    parameter int unsigned AUX_TID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid_i,
    input  logic [TID_W-1:0]  res_tid_i,
    input  logic [IDX_W-1:0]  res_idx_i,
    input  logic [DATA_W-1:0] res_data_i,
    output logic              rf_we_o,
    output logic [IDX_W-1:0]  rf_idx_o,
    output logic [DATA_W-1:0] rf_data_o,
    output logic              mismatch_o,
    output logic              recover_o,
    output logic              fatal_o
);

    import wbv_pkg::*;

    localparam int unsigned WORD_W = IDX_W + DATA_W;
    // The two primary slots are whichever slots are not the auxiliary one
    localparam int unsigned P0 = (AUX_TID == 0) ? 1 : 0;
    localparam int unsigned P1 = (AUX_TID == 2) ? 1 : 2;

    typedef struct packed {
        vmode_e            mode;
        logic              we;
        logic              mis;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_SLOTS-1:0] take;
    logic [NUM_SLOTS-1:0] full;
    logic [WORD_W-1:0]    slot_word [NUM_SLOTS];
    logic [WORD_W-1:0]    in_word;
    logic                 clr_all;
    logic                 pair_eq;
    logic                 maj_ok;
    logic [WORD_W-1:0]    maj_word;

    assign in_word = {res_idx_i, res_data_i};

    wbv_route #(
        .TID_W     (TID_W),
        .NUM_SLOTS (NUM_SLOTS),
        .AUX_TID   (AUX_TID)
    ) u_route (
        .valid_i        (res_valid_i),
        .tid_i          (res_tid_i),
        .pair_mode_i    (ctl_q.mode == MODE_PAIR),
        .recover_mode_i (ctl_q.mode == MODE_RECOVER),
        .take_o         (take)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        wbv_slot #(
            .WORD_W (WORD_W)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .take_i (take[g]),
            .clr_i  (clr_all),
            .word_i (in_word),
            .full_o (full[g]),
            .word_o (slot_word[g])
        );
    end

    wbv_vote3 #(
        .WORD_W (WORD_W)
    ) u_vote (
        .a_i        (slot_word[P0]),
        .b_i        (slot_word[P1]),
        .c_i        (slot_word[AUX_TID]),
        .pair_eq_o  (pair_eq),
        .maj_ok_o   (maj_ok),
        .maj_word_o (maj_word)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.we  = 1'b0;
        ctl_d.mis = 1'b0;
        clr_all   = 1'b0;
        case (ctl_q.mode)
            MODE_PAIR: begin
                if (full[P0] && full[P1]) begin
                    if (pair_eq) begin
                        clr_all                = 1'b1;
                        ctl_d.we               = 1'b1;
                        {ctl_d.idx, ctl_d.data} = slot_word[P0];
                    end else begin
                        // keep both copies for the three-way vote
                        ctl_d.mis  = 1'b1;
                        ctl_d.mode = MODE_RECOVER;
                    end
                end
            end
            MODE_RECOVER: begin
                if (full[AUX_TID]) begin
                    clr_all = 1'b1;
                    if (maj_ok) begin
                        ctl_d.we               = 1'b1;
                        {ctl_d.idx, ctl_d.data} = maj_word;
                        ctl_d.mode             = MODE_PAIR;
                    end else begin
                        ctl_d.mode = MODE_DEAD;
                    end
                end
            end
            default: begin
                // dead: hold until reset
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rf_we_o    = ctl_q.we;
    assign rf_idx_o   = ctl_q.idx;
    assign rf_data_o  = ctl_q.data;
    assign mismatch_o = ctl_q.mis;
    assign recover_o  = (ctl_q.mode == MODE_RECOVER);
    assign fatal_o    = (ctl_q.mode == MODE_DEAD);

endmodule

// File: rtl/wbv_chk.sv
module wbv_chk (
    input logic clk,
    input logic rst_n,
    input logic rf_we_o,
    input logic mismatch_o,
    input logic recover_o,
    input logic fatal_o
);

    // R2
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |=> !rf_we_o);

    // R4
    mis_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |-> (!rf_we_o && recover_o));

    // R4
    mis_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |=> !mismatch_o);

    // R5
    recover_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recover_o |-> !rf_we_o);

    // R5
    resolve_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(recover_o) && !fatal_o) |-> rf_we_o);

    // R6
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> (fatal_o && !rf_we_o && !recover_o));

endmodule

bind wbv_top wbv_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rf_we_o    (rf_we_o),
    .mismatch_o (mismatch_o),
    .recover_o  (recover_o),
    .fatal_o    (fatal_o)
);

// File: tb/sim_wbv_top.sv
module sim_wbv_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v = 1'b0;
    logic [1:0]  tid = '0;
    logic [4:0]  idx = '0;
    logic [31:0] dat = '0;
    logic        rf_we, mism, recov, fatal;
    logic [4:0]  rf_idx;
    logic [31:0] rf_data;
    int          checks = 0;
    int          errs = 0;

    // 4-unit period: 250 MHz with 1 ns units
    always #2 clk = ~clk;

    wbv_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_valid_i (v),
        .res_tid_i   (tid),
        .res_idx_i   (idx),
        .res_data_i  (dat),
        .rf_we_o     (rf_we),
        .rf_idx_o    (rf_idx),
        .rf_data_o   (rf_data),
        .mismatch_o  (mism),
        .recover_o   (recov),
        .fatal_o     (fatal)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; the copy is captured at the next posedge and the
    // task returns at the negedge after it.
    task automatic put(input logic [1:0] t, input logic [4:0] i, input logic [31:0] d);
        v = 1'b1; tid = t; idx = i; dat = d;
        @(negedge clk);
        v = 1'b0;
    endtask

    task automatic expect_write(input string req, input logic [4:0] i, input logic [31:0] d);
        chk(req, "we", 64'(rf_we), 64'd1);
        chk(req, "idx", 64'(rf_idx), 64'(i));
        chk(req, "data", 64'(rf_data), 64'(d));
    endtask

    task automatic t_reset();
        chk("R1", "we", 64'(rf_we), 0);
        chk("R1", "mismatch", 64'(mism), 0);
        chk("R1", "recover", 64'(recov), 0);
        chk("R1", "fatal", 64'(fatal), 0);
    endtask

    task automatic t_match();
        put(2, 5, 32'hA5A5_0001);
        @(negedge clk);
        chk("R3", "we one copy", 64'(rf_we), 0);
        put(1, 5, 32'hA5A5_0001);
        @(negedge clk);
        expect_write("R2", 5, 32'hA5A5_0001);
        @(negedge clk);
        chk("R2", "we pulse end", 64'(rf_we), 0);
    endtask

    task automatic t_reverse_gap();
        put(1, 17, 32'h1234_5678);
        repeat (4) @(negedge clk);
        chk("R3", "we after gap", 64'(rf_we), 0);
        put(2, 17, 32'h1234_5678);
        @(negedge clk);
        expect_write("R2", 17, 32'h1234_5678);
    endtask

    task automatic t_data_mismatch();
        put(2, 7, 32'h0000_00F0);
        put(1, 7, 32'h0000_00F1);
        @(negedge clk);
        chk("R4", "we", 64'(rf_we), 0);
        chk("R4", "mismatch", 64'(mism), 1);
        chk("R4", "recover", 64'(recov), 1);
        @(negedge clk);
        chk("R4", "mismatch pulse end", 64'(mism), 0);
        chk("R4", "recover held", 64'(recov), 1);
        put(0, 7, 32'h0000_00F1);
        chk("R5", "recover before vote", 64'(recov), 1);
        @(negedge clk);
        expect_write("R5", 7, 32'h0000_00F1);
        chk("R5", "recover dropped", 64'(recov), 0);
    endtask

    task automatic t_idx_mismatch();
        put(2, 3, 32'hDEAD_BEEF);
        put(1, 4, 32'hDEAD_BEEF);
        @(negedge clk);
        chk("R4", "idx mismatch", 64'(mism), 1);
        put(0, 3, 32'hDEAD_BEEF);
        @(negedge clk);
        expect_write("R5", 3, 32'hDEAD_BEEF);
        // buffers must be empty after resolution
        put(2, 9, 32'h0000_0999);
        repeat (2) @(negedge clk);
        chk("R7", "we after resolve", 64'(rf_we), 0);
        put(1, 9, 32'h0000_0999);
        @(negedge clk);
        expect_write("R7", 9, 32'h0000_0999);
        // and after a normal commit
        put(1, 10, 32'h0000_0AAA);
        repeat (2) @(negedge clk);
        chk("R7", "we after commit", 64'(rf_we), 0);
        put(2, 10, 32'h0000_0AAA);
        @(negedge clk);
        expect_write("R7", 10, 32'h0000_0AAA);
    endtask

    task automatic t_ignored_tids();
        put(0, 1, 32'h0000_0011);
        put(2, 1, 32'h0000_0022);
        put(1, 1, 32'h0000_0011);
        @(negedge clk);
        chk("R4", "mismatch", 64'(mism), 1);
        repeat (3) @(negedge clk);
        chk("R8", "aux in pair mode ignored", 64'(recov), 1);
        chk("R8", "we", 64'(rf_we), 0);
        put(0, 1, 32'h0000_0022);
        @(negedge clk);
        expect_write("R5", 1, 32'h0000_0022);
        put(2, 2, 32'h0000_3333);
        put(3, 2, 32'h0000_3333);
        repeat (2) @(negedge clk);
        chk("R8", "tid3 ignored", 64'(rf_we), 0);
        put(1, 2, 32'h0000_3333);
        @(negedge clk);
        expect_write("R8", 2, 32'h0000_3333);
    endtask

    task automatic t_duplicate();
        put(2, 6, 32'h0000_6666);
        put(2, 6, 32'h0000_7777);
        put(1, 6, 32'h0000_6666);
        @(negedge clk);
        expect_write("R9", 6, 32'h0000_6666);
        chk("R9", "mismatch", 64'(mism), 0);
    endtask

    task automatic t_back_to_back();
        put(2, 8, 32'h0000_8888);
        put(1, 8, 32'h0000_8888);
        put(2, 11, 32'h0000_BBBB);
        expect_write("R10", 8, 32'h0000_8888);
        put(1, 11, 32'h0000_BBBB);
        @(negedge clk);
        expect_write("R10", 11, 32'h0000_BBBB);
    endtask

    task automatic t_fatal();
        put(2, 4, 32'h1);
        put(1, 4, 32'h2);
        @(negedge clk);
        chk("R4", "mismatch", 64'(mism), 1);
        put(0, 4, 32'h3);
        @(negedge clk);
        chk("R6", "fatal", 64'(fatal), 1);
        chk("R6", "we", 64'(rf_we), 0);
        chk("R6", "recover", 64'(recov), 0);
        put(2, 4, 32'h5);
        put(1, 4, 32'h5);
        repeat (2) @(negedge clk);
        chk("R6", "inputs ignored", 64'(rf_we), 0);
        chk("R6", "fatal sticky", 64'(fatal), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "fatal cleared", 64'(fatal), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_match();
        t_reverse_gap();
        t_data_mismatch();
        t_idx_mismatch();
        t_ignored_tids();
        t_duplicate();
        t_back_to_back();
        t_fatal();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule